// File: doc/BRIEF.md
# Rejected Interrupt Retry Bitmap

This block remembers interrupt sources that the interrupt presenter turned away, and later replays them. Each reject carries a global interrupt number. The block subtracts a base offset from it to form a local source number, then records that source in a two-level bitmap. The bitmap has 32 words of 64 bits each, and a 32-bit summary above them holds one bit per word.

A resend command starts a scan in ascending source order. The summary lets the scan skip words that hold no recorded source. For each recorded source the scan clears the bit and offers one forced trigger to the trigger engine over a valid/ready handshake. When the scan ends, the block pulses done.

Rejects keep arriving and are recorded while a scan runs. A reject whose position the scan has already passed stays recorded until the next resend.

Top module: `reject_retry_map`

## Requirements
- R1: After reset the bitmap and summary are empty, and `trig_valid`, `done` and `busy` are low.
- R2: A reject with `rej_valid` high records local source `rej_girq - irq_base`, and a later resend offers exactly that value on `trig_src`.
- R3: A reject whose global number is below `irq_base`, or whose local number is 2048 or more, is ignored and produces no retry.
- R4: A resend while nothing is recorded offers no trigger, and pulses `done` within three clock cycles of the command.
- R5: A scan offers the recorded sources in strictly ascending order, covering words 0 to 31 and bits 0 to 63 within each word, and skips words whose summary bit is clear.
- R6: Once `trig_valid` is high it stays high, with `trig_src` unchanged, until `trig_ready` is seen high. Each accepted handshake moves exactly one retry.
- R7: Each retried source is cleared, so a second resend with no new rejects offers nothing.
- R8: A reject that arrives during a scan is never lost. If its position lies ahead of the scan, it is retried in the same scan. If the scan has already passed it, it is retried by the next resend.
- R9: `resend_req` is ignored while `busy` is high.
- R10: `done` is a single-cycle pulse at the end of each scan. When it is high, `busy` and `trig_valid` are low.
- R11: Rejecting the same source several times before a resend gives a single retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rej_valid | input | 1 | Reject event strobe |
| rej_girq | input | GW | Global interrupt number of the rejected source |
| irq_base | input | GW | Global number of local source 0 |
| resend_req | input | 1 | Start a retry scan |
| trig_ready | input | 1 | Trigger engine accepts a retry |
| trig_valid | output | 1 | A forced retry is offered |
| trig_src | output | 11 | Local source number of the offered retry |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan finished (one-cycle pulse) |

## Verification
A lost or stale bitmap bit shows up at the ports in the next scan. It appears as a missing, repeated or out-of-order value in the `trig_src` sequence, or as a retry after a second resend that should be silent. A wrong scan pointer reorders or skips sources as soon as the scan reaches the affected word. A broken handshake hold changes `trig_src` during a stalled cycle, and the bench sees it at the next clock edge.

// File: rtl/reject_retry_map.sv
module reject_retry_map #(
  parameter int NWORDS = 32,
  parameter int WBITS  = 64,
  parameter int GW     = 16
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    rej_valid,
  input  logic [GW-1:0]                           rej_girq,
  input  logic [GW-1:0]                           irq_base,
  input  logic                                    resend_req,
  input  logic                                    trig_ready,
  output logic                                    trig_valid,
  output logic [$clog2(NWORDS)+$clog2(WBITS)-1:0] trig_src,
  output logic                                    busy,
  output logic                                    done
);
  localparam int WIDX_W = $clog2(NWORDS);
  localparam int BIDX_W = $clog2(WBITS);
  localparam int SRC_W  = WIDX_W + BIDX_W;
  localparam int NSRC   = NWORDS * WBITS;

  typedef enum logic [1:0] {S_IDLE, S_FIND, S_BITS, S_WAIT} st_t;

  logic [NWORDS-1:0][WBITS-1:0] bmap;
  logic [NWORDS-1:0]            summ;
  st_t                          st;
  logic [WIDX_W-1:0]            wp;
  logic [BIDX_W:0]              bp;

  function automatic logic [WIDX_W-1:0] low_w(input logic [NWORDS-1:0] v);
    logic [WIDX_W-1:0] r;
    r = '0;
    for (int i = NWORDS - 1; i >= 0; i--) if (v[i]) r = WIDX_W'(i);
    return r;
  endfunction

  function automatic logic [BIDX_W-1:0] low_b(input logic [WBITS-1:0] v);
    logic [BIDX_W-1:0] r;
    r = '0;
    for (int i = WBITS - 1; i >= 0; i--) if (v[i]) r = BIDX_W'(i);
    return r;
  endfunction

  logic [GW:0]        diff;
  logic               rej_ok;
  logic [SRC_W-1:0]   rej_src;
  logic [WIDX_W-1:0]  rw;
  logic [BIDX_W-1:0]  rb;
  logic [NWORDS-1:0]  wcand;
  logic [WBITS-1:0]   bcand;
  logic [WIDX_W-1:0]  widx;
  logic [BIDX_W-1:0]  bidx;
  logic               clr_sum, clr_bit, last_w;

  assign diff    = {1'b0, rej_girq} - {1'b0, irq_base};
  assign rej_ok  = rej_valid && !diff[GW] && ({1'b0, diff[GW-1:0]} < (GW+1)'(NSRC));
  assign rej_src = diff[SRC_W-1:0];
  assign rw      = rej_src[SRC_W-1:BIDX_W];
  assign rb      = rej_src[BIDX_W-1:0];
  assign wcand   = summ & ({NWORDS{1'b1}} << wp);
  assign bcand   = bmap[wp] & ({WBITS{1'b1}} << bp);
  assign widx    = low_w(wcand);
  assign bidx    = low_b(bcand);
  assign clr_sum = (st == S_FIND) && |wcand;
  assign clr_bit = (st == S_BITS) && |bcand;
  assign last_w  = (wp == WIDX_W'(NWORDS - 1));
  assign busy    = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bmap <= '0;
      summ <= '0;
    end else begin
      if (clr_bit) bmap[wp][bidx] <= 1'b0;
      if (clr_sum) summ[widx] <= 1'b0;
      if (rej_ok) begin
        bmap[rw][rb] <= 1'b1;
        summ[rw]     <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      wp         <= '0;
      bp         <= '0;
      trig_valid <= 1'b0;
      trig_src   <= '0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (resend_req) begin
          wp <= '0;
          st <= S_FIND;
        end
        S_FIND: if (|wcand) begin
          wp <= widx;
          bp <= '0;
          st <= S_BITS;
        end else begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
        S_BITS: if (|bcand) begin
          trig_src   <= {wp, bidx};
          trig_valid <= 1'b1;
          bp         <= {1'b0, bidx} + 1'b1;
          st         <= S_WAIT;
        end else if (last_w) begin
          done <= 1'b1;
          st   <= S_IDLE;
        end else begin
          wp <= wp + 1'b1;
          st <= S_FIND;
        end
        S_WAIT: if (trig_ready) begin
          trig_valid <= 1'b0;
          st         <= S_BITS;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid && !trig_ready |=> trig_valid && $stable(trig_src));
  p_valid_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid |-> busy);
  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !trig_valid);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_record_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rej_ok |=> bmap[$past(rw)][$past(rb)] && summ[$past(rw)]);
  p_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && resend_req && summ == '0 && !rej_ok |=> !trig_valid ##1 (done && !trig_valid));
endmodule

// File: tb/test_reject_retry_map.sv
module test_reject_retry_map;
  localparam int NSRC = 2048;
  logic clk = 0, rst_n = 0;
  logic rej_valid = 0, resend_req = 0, trig_ready = 0;
  logic [15:0] rej_girq = 0, irq_base = 0;
  logic trig_valid, busy, done;
  logic [10:0] trig_src;

  reject_retry_map i_reject_retry_map (.*);

  always #2 clk = ~clk;

  int total = 0, bad = 0, cyc = 0, rdy_mode = 0;
  int rcv [0:4095];
  int rcv_n = 0, done_cnt = 0;
  bit model [0:NSRC-1];
  logic pv = 0, pr = 0;
  logic [10:0] ps = 0;

  // (base, girq) pairs; duplicates 163/100 and 50063/50000 cover R11
  localparam logic [31:0] VEC [12] = '{
    {16'd100, 16'd100}, {16'd100, 16'd163}, {16'd100, 16'd164}, {16'd100, 16'd99},
    {16'd100, 16'd2147}, {16'd100, 16'd2148}, {16'd100, 16'd3000}, {16'd100, 16'd1100},
    {16'd100, 16'd163}, {16'd0, 16'd5}, {16'd0, 16'd130}, {16'd50000, 16'd50063}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    #1;
    case (rdy_mode)
      0: trig_ready = 1;
      1: trig_ready = (cyc % 3) != 0;
      default: trig_ready = 0;
    endcase
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (pv && !pr) chk(trig_valid && trig_src == ps, "R6 hold", trig_src, ps);
    if (trig_valid && trig_ready) begin rcv[rcv_n] = trig_src; rcv_n++; end
    if (done) done_cnt++;
    pv = trig_valid; pr = trig_ready; ps = trig_src;
  end

  task automatic reject(input int base, input int girq);
    @(posedge clk); #1;
    rej_valid = 1; irq_base = 16'(base); rej_girq = 16'(girq);
    if (girq >= base && girq - base < NSRC) model[girq - base] = 1;
    @(posedge clk); #1;
    rej_valid = 0;
  endtask

  task automatic start_resend();
    @(posedge clk); #1; resend_req = 1;
    @(posedge clk); #1; resend_req = 0;
  endtask

  task automatic wait_done(input int d0);
    for (int k = 0; k < 20000 && done_cnt == d0; k++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic compare(input string req);
    int k, n;
    k = 0; n = 0;
    for (int i = 0; i < NSRC; i++) if (model[i]) begin
      if (k < rcv_n) chk(rcv[k] == i, req, rcv[k], i);
      else chk(0, req, -1, i);
      k++; model[i] = 0;
    end
    n = k;
    chk(rcv_n == n, "R11 retry count", rcv_n, n);
    rcv_n = 0;
  endtask

  initial begin
    int d0, t0;
    repeat (3) @(posedge clk);
    #1;
    chk(!trig_valid && !done && !busy, "R1 reset outputs", {trig_valid, done, busy}, 0);
    rst_n = 1;
    // R4 empty resend
    d0 = done_cnt; t0 = cyc;
    start_resend();
    wait_done(d0);
    chk(rcv_n == 0, "R4 no trigger", rcv_n, 0);
    chk(cyc - t0 <= 5, "R4 done latency", cyc - t0, 5);
    // R2 R5 table walk with a stalling ready
    for (int v = 0; v < 12; v++) reject(VEC[v][31:16], VEC[v][15:0]);
    rdy_mode = 1;
    d0 = done_cnt;
    start_resend();
    wait_done(d0);
    compare("R5 order / R2 value");
    chk(!busy && !trig_valid, "R10 idle after done", busy, 0);
    // R7 second resend silent
    d0 = done_cnt;
    start_resend();
    wait_done(d0);
    chk(rcv_n == 0, "R7 cleared", rcv_n, 0);
    // R3 only out-of-range rejects
    reject(100, 2148); reject(100, 50); reject(0, 2048);
    d0 = done_cnt;
    start_resend();
    wait_done(d0);
    chk(rcv_n == 0, "R3 ignored", rcv_n, 0);
    // R8 / R9 rejects and resend during a stalled scan
    reject(0, 5); reject(0, 200);
    rdy_mode = 2;
    d0 = done_cnt;
    start_resend();
    repeat (6) @(posedge clk);
    chk(busy && trig_valid && trig_src == 5, "R8 stalled on first", trig_src, 5);
    reject(0, 1000);
    @(posedge clk); #1; rej_valid = 1; irq_base = 0; rej_girq = 2;
    @(posedge clk); #1; rej_valid = 0;
    start_resend();
    model[2] = 0;
    rdy_mode = 0;
    wait_done(d0);
    repeat (10) @(negedge clk);
    chk(done_cnt == d0 + 1, "R9 extra resend ignored", done_cnt, d0 + 1);
    compare("R8 ahead retried");
    model[2] = 1;
    d0 = done_cnt;
    start_resend();
    wait_done(d0);
    compare("R8 passed waits");
    // R1 reset clears recorded state
    reject(0, 77);
    model[77] = 0;
    @(posedge clk); #1 rst_n = 0;
    @(posedge clk); #1 rst_n = 1;
    d0 = done_cnt;
    start_resend();
    wait_done(d0);
    chk(rcv_n == 0, "R1 reset clears map", rcv_n, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule